// File: doc/BRIEF.md
# Completion Ring Consumer with Phase Check

This block is the reading end of a completion ring that a device fills. The device writes 128-bit completion entries into a ring of 2^RING_LOG2 slots, plus one extra status word at slot index 2^RING_LOG2 whose bit 0 signals that the queue is in error. The consumer keeps a read pointer one bit wider than the ring index. The top pointer bit is the wrap phase. An entry is taken as new only when its generation bit differs from that phase bit. After each full lap the expected generation value flips, so stale entries left over from the previous lap are never consumed twice.

Alongside the ring, software may push its own completion entries into a small local queue. While that queue holds anything, its head is presented before any ring entry. The selected entry is split into its header fields, given a few derived flags, and offered on a valid/ready output. A handshake moves only the queue that supplied the entry. What the status codes mean and which request a completion belongs to are left to the logic downstream.

Top module: `cq_consumer`

## Requirements
- R1: After synchronous reset, cq_valid is 0, hw_rptr is 0, q_err is 0 and sw_ready is 1. Every ring slot reads back with generation bit 0.
- R2: With the software queue empty, cq_valid is 1 exactly when the generation bit (header bit 10) of the ring entry at index hw_rptr[RING_LOG2-1:0] equals the inverse of hw_rptr[RING_LOG2].
- R3: While the software queue is non-empty, its oldest entry is presented with cq_from_sw=1, whatever the ring holds. Consuming it leaves hw_rptr unchanged.
- R4: The presented entry packs its header in bits 31:0, its length in bits 63:32, and its third and fourth words in bits 95:64 and 127:96. The header fields come out as: cq_ooo from bit 31, cq_qid from bits 30:12, cq_swgen from bit 11, cq_gen from bit 10, cq_status from bits 9:5, cq_sendq from bit 4 and cq_opcode from bits 3:0.
- R5: cq_sendq is 1 for a send-side completion (type bit 1) and 0 for a receive-side completion.
- R6: cq_send_class is 1 exactly when cq_opcode is 3, 4, 5 or 6.
- R7: cq_ok is 1 exactly when cq_status is 0. cq_internal_err is 1 exactly when cq_status is 0x1F.
- R8: hw_rptr moves only on a cycle with cq_valid and cq_ready both high and cq_from_sw low. It then increments by one modulo 2^(RING_LOG2+1), which flips the phase bit after every lap.
- R9: A device write to address 2^RING_LOG2 sets q_err to bit 0 of the written data. Writes to addresses above 2^RING_LOG2 change nothing.
- R10: sw_ready is 0 when the software queue holds 2^SW_LOG2 entries. A push in that state is dropped, even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_we | input | 1 | Device write strobe |
| dev_addr | input | RING_LOG2+1 | Ring slot, or the status slot at 2^RING_LOG2 |
| dev_data | input | 128 | Entry data; bit 0 carries the error flag for the status slot |
| sw_push | input | 1 | Push a software completion |
| sw_data | input | 128 | Software completion entry |
| sw_ready | output | 1 | Software queue has room |
| cq_valid | output | 1 | An entry is presented |
| cq_ready | input | 1 | Downstream accepts the entry |
| cq_from_sw | output | 1 | Entry came from the software queue |
| cq_ooo | output | 1 | Out-of-order flag |
| cq_qid | output | 19 | Queue identifier |
| cq_swgen | output | 1 | Software-generated flag |
| cq_gen | output | 1 | Generation bit |
| cq_status | output | 5 | Completion status code |
| cq_sendq | output | 1 | 1 for send side, 0 for receive side |
| cq_opcode | output | 4 | Operation code |
| cq_send_class | output | 1 | Opcode is one of the send variants |
| cq_ok | output | 1 | Status is success |
| cq_internal_err | output | 1 | Status is internal error |
| cq_len | output | 32 | Length word |
| cq_w2 | output | 32 | Third word (tag or request-id half) |
| cq_w3 | output | 32 | Fourth word (sequence or request-id half) |
| hw_rptr | output | RING_LOG2+1 | Ring read pointer including the phase bit |
| q_err | output | 1 | Queue error flag |

## Verification
The bench uses RING_LOG2=3 and SW_LOG2=2, so the ring has eight slots and the software queue holds four entries. With eight slots, several full laps of the pointer fit in a short run. This exercises the phase flip, including stale entries from the previous lap being refused. With four queue entries, the full condition and the dropped push are reached after a few pushes, and simultaneous push and pop can be tried there. A random phase then mixes device writes to every slot, the status slot and the ignored address above it with pushes and random ready patterns. All opcode and status values appear in that phase.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 4 * WORD_W;

    typedef struct packed {
        logic        ooo;
        logic [18:0] qid;
        logic        swgen;
        logic        gen;
        logic [4:0]  status;
        logic        sendq;
        logic [3:0]  opcode;
    } cq_hdr_t;

    typedef struct packed {
        logic [WORD_W-1:0] w3;
        logic [WORD_W-1:0] w2;
        logic [WORD_W-1:0] len;
        cq_hdr_t           hdr;
    } cq_entry_t;

    typedef struct packed {
        logic send_class;
        logic ok;
        logic internal_err;
    } cq_flags_t;

    localparam logic [4:0] ST_SUCCESS  = 5'h00;
    localparam logic [4:0] ST_INTERNAL = 5'h1F;

    function automatic logic is_send_op(input logic [3:0] op);
        return (op >= 4'd3) && (op <= 4'd6);
    endfunction

endpackage

// File: rtl/cq_ring_store.sv
module cq_ring_store
    import cq_pkg::*;
#(
    parameter int RING_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [RING_LOG2:0]   addr,
    input  cq_entry_t            wdata,
    input  logic [RING_LOG2-1:0] rd_idx,
    output cq_entry_t            rd_entry,
    output logic                 err_flag
);
    localparam int SLOTS = 1 << RING_LOG2;
    localparam logic [RING_LOG2:0] STATUS_ADDR = (RING_LOG2+1)'(SLOTS);

    cq_entry_t slot_q [SLOTS];
    logic      err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
            err_q <= 1'b0;
        end else if (we) begin
            if (addr < STATUS_ADDR)
                slot_q[addr[RING_LOG2-1:0]] <= wdata;
            else if (addr == STATUS_ADDR)
                err_q <= wdata.hdr.opcode[0];
        end
    end

    assign rd_entry = slot_q[rd_idx];
    assign err_flag = err_q;

endmodule

// File: rtl/cq_sw_fifo.sv
module cq_sw_fifo
    import cq_pkg::*;
#(
    parameter int SW_LOG2 = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  cq_entry_t push_data,
    input  logic      pop,
    output logic      full,
    output logic      empty,
    output cq_entry_t head
);
    localparam int DEPTH = 1 << SW_LOG2;

    cq_entry_t          buf_q [DEPTH];
    logic [SW_LOG2:0]   wr_q, rd_q;

    assign empty = (wr_q == rd_q);
    assign full  = (wr_q[SW_LOG2] != rd_q[SW_LOG2]) &&
                   (wr_q[SW_LOG2-1:0] == rd_q[SW_LOG2-1:0]);
    assign head  = buf_q[rd_q[SW_LOG2-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push && !full) begin
                buf_q[wr_q[SW_LOG2-1:0]] <= push_data;
                wr_q <= wr_q + 1'b1;
            end
            if (pop && !empty)
                rd_q <= rd_q + 1'b1;
        end
    end

endmodule

// File: rtl/cq_hdr_decode.sv
module cq_hdr_decode
    import cq_pkg::*;
(
    input  logic [3:0] opcode,
    input  logic [4:0] status,
    output cq_flags_t  flags
);
    always_comb begin
        flags.send_class   = is_send_op(opcode);
        flags.ok           = (status == ST_SUCCESS);
        flags.internal_err = (status == ST_INTERNAL);
    end
endmodule

// File: rtl/cq_consumer.sv
module cq_consumer
    import cq_pkg::*;
#(
    parameter int RING_LOG2 = 3,
    parameter int SW_LOG2   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dev_we,
    input  logic [RING_LOG2:0]   dev_addr,
    input  logic [ENTRY_W-1:0]   dev_data,
    input  logic                 sw_push,
    input  logic [ENTRY_W-1:0]   sw_data,
    output logic                 sw_ready,
    output logic                 cq_valid,
    input  logic                 cq_ready,
    output logic                 cq_from_sw,
    output logic                 cq_ooo,
    output logic [18:0]          cq_qid,
    output logic                 cq_swgen,
    output logic                 cq_gen,
    output logic [4:0]           cq_status,
    output logic                 cq_sendq,
    output logic [3:0]           cq_opcode,
    output logic                 cq_send_class,
    output logic                 cq_ok,
    output logic                 cq_internal_err,
    output logic [WORD_W-1:0]    cq_len,
    output logic [WORD_W-1:0]    cq_w2,
    output logic [WORD_W-1:0]    cq_w3,
    output logic [RING_LOG2:0]   hw_rptr,
    output logic                 q_err
);
    cq_entry_t          ring_ent, sw_head, sel_ent;
    cq_flags_t          flags;
    logic               sw_full, sw_empty, hw_fresh, use_sw, fire;
    logic [RING_LOG2:0] rptr_q;

    cq_ring_store #(.RING_LOG2(RING_LOG2)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (dev_we),
        .addr     (dev_addr),
        .wdata    (cq_entry_t'(dev_data)),
        .rd_idx   (rptr_q[RING_LOG2-1:0]),
        .rd_entry (ring_ent),
        .err_flag (q_err)
    );

    cq_sw_fifo #(.SW_LOG2(SW_LOG2)) u_swq (
        .clk       (clk),
        .rst       (rst),
        .push      (sw_push),
        .push_data (cq_entry_t'(sw_data)),
        .pop       (fire && use_sw),
        .full      (sw_full),
        .empty     (sw_empty),
        .head      (sw_head)
    );

    // phase: entry is new when its generation bit differs from the wrap bit
    assign hw_fresh = (ring_ent.hdr.gen != rptr_q[RING_LOG2]);
    assign use_sw   = !sw_empty;
    assign sel_ent  = use_sw ? sw_head : ring_ent;
    assign cq_valid = use_sw || hw_fresh;
    assign fire     = cq_valid && cq_ready;

    always_ff @(posedge clk) begin
        if (rst)
            rptr_q <= '0;
        else if (fire && !use_sw)
            rptr_q <= rptr_q + 1'b1;
    end

    cq_hdr_decode u_dec (
        .opcode (sel_ent.hdr.opcode),
        .status (sel_ent.hdr.status),
        .flags  (flags)
    );

    assign sw_ready        = !sw_full;
    assign cq_from_sw      = use_sw;
    assign cq_ooo          = sel_ent.hdr.ooo;
    assign cq_qid          = sel_ent.hdr.qid;
    assign cq_swgen        = sel_ent.hdr.swgen;
    assign cq_gen          = sel_ent.hdr.gen;
    assign cq_status       = sel_ent.hdr.status;
    assign cq_sendq        = sel_ent.hdr.sendq;
    assign cq_opcode       = sel_ent.hdr.opcode;
    assign cq_send_class   = flags.send_class;
    assign cq_ok           = flags.ok;
    assign cq_internal_err = flags.internal_err;
    assign cq_len          = sel_ent.len;
    assign cq_w2           = sel_ent.w2;
    assign cq_w3           = sel_ent.w3;
    assign hw_rptr         = rptr_q;

endmodule

// File: rtl/cq_consumer_chk.sv
module cq_consumer_chk #(
    parameter int RING_LOG2 = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cq_valid,
    input logic               cq_ready,
    input logic               cq_from_sw,
    input logic               cq_gen,
    input logic [3:0]         cq_opcode,
    input logic               cq_send_class,
    input logic               cq_ok,
    input logic               cq_internal_err,
    input logic [RING_LOG2:0] hw_rptr
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hw_rptr == '0 && !cq_valid)); // R1

    AST_HW_PHASE: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && !cq_from_sw) |-> (cq_gen != hw_rptr[RING_LOG2])); // R2

    AST_SW_KEEPS_RPTR: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && cq_ready && cq_from_sw) |=> $stable(hw_rptr)); // R3

    AST_SEND_CLASS: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && cq_send_class) |-> (cq_opcode >= 4'd3 && cq_opcode <= 4'd6)); // R6

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cq_ok && cq_internal_err)); // R7

    AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cq_valid && cq_ready) |=> $stable(hw_rptr)); // R8

    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cq_valid && cq_ready && !cq_from_sw) |=> (hw_rptr == $past(hw_rptr) + 1'b1)); // R8
endmodule

bind cq_consumer cq_consumer_chk #(.RING_LOG2(RING_LOG2)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cq_valid        (cq_valid),
    .cq_ready        (cq_ready),
    .cq_from_sw      (cq_from_sw),
    .cq_gen          (cq_gen),
    .cq_opcode       (cq_opcode),
    .cq_send_class   (cq_send_class),
    .cq_ok           (cq_ok),
    .cq_internal_err (cq_internal_err),
    .hw_rptr         (hw_rptr)
);

// File: tb/cq_consumer_tb.sv
module cq_consumer_tb_top;
    localparam int RL    = 3;
    localparam int SLOTS = 1 << RL;
    localparam int SWD   = 4;

    logic         clk = 0, rst = 1;
    logic         dev_we = 0, sw_push = 0, cq_ready = 0;
    logic [RL:0]  dev_addr = '0;
    logic [127:0] dev_data = '0, sw_data = '0;
    logic         sw_ready, cq_valid, cq_from_sw, cq_ooo, cq_swgen, cq_gen;
    logic [18:0]  cq_qid;
    logic [4:0]   cq_status;
    logic         cq_sendq, cq_send_class, cq_ok, cq_internal_err, q_err;
    logic [3:0]   cq_opcode;
    logic [31:0]  cq_len, cq_w2, cq_w3;
    logic [RL:0]  hw_rptr;

    always #5 clk = ~clk;

    cq_consumer #(.RING_LOG2(RL), .SW_LOG2(2)) dut_i (.*);

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model
    logic [127:0] m_ring [SLOTS];
    logic [127:0] m_sw [$];
    int           m_rptr = 0;
    bit           m_err = 0;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] mk(bit ooo, logic [18:0] qid, bit swg, bit gen,
                                        logic [4:0] st, bit ty, logic [3:0] op, logic [31:0] tag);
        logic [31:0] h;
        h = {ooo, qid, swg, gen, st, ty, op};
        return {tag ^ 32'h5a5a0000, tag + 32'd7, tag, h};
    endfunction

    function automatic bit m_hw_fresh();
        logic [127:0] e = m_ring[m_rptr % SLOTS];
        return e[10] == !((m_rptr / SLOTS) % 2);
    endfunction

    task automatic compare_all();
        logic [127:0] e;
        bit ev, esw;
        esw = (m_sw.size() > 0);
        ev  = esw || m_hw_fresh();
        e   = esw ? m_sw[0] : m_ring[m_rptr % SLOTS];
        chk("R10 sw_ready", sw_ready, m_sw.size() < SWD);
        chk("R8 hw_rptr", hw_rptr, m_rptr);
        chk("R9 q_err", q_err, m_err);
        chk("R2 cq_valid", cq_valid, ev);
        if (ev) begin
            chk("R3 cq_from_sw", cq_from_sw, esw);
            chk("R4 header", {cq_ooo, cq_qid, cq_swgen, cq_gen, cq_status, cq_sendq, cq_opcode}, e[31:0]);
            chk("R4 words", {cq_w3, cq_w2, cq_len}, e[127:32]);
            chk("R5 cq_sendq", cq_sendq, e[4]);
            chk("R6 cq_send_class", cq_send_class, (e[3:0] >= 3 && e[3:0] <= 6));
            chk("R7 cq_ok", cq_ok, e[9:5] == 5'd0);
            chk("R7 cq_internal_err", cq_internal_err, e[9:5] == 5'h1f);
        end
    endtask

    task automatic step(bit we, int addr, logic [127:0] d, bit push, logic [127:0] pd, bit rdy);
        bit esw, ev, can_push;
        @(negedge clk);
        compare_all();
        dev_we = we; dev_addr = addr[RL:0]; dev_data = d;
        sw_push = push; sw_data = pd; cq_ready = rdy;
        esw = (m_sw.size() > 0);
        ev  = esw || m_hw_fresh();
        can_push = (m_sw.size() < SWD);
        if (ev && rdy) begin
            if (esw) void'(m_sw.pop_front());
            else m_rptr = (m_rptr + 1) % (2 * SLOTS);
        end
        if (push && can_push) m_sw.push_back(pd);
        if (we) begin
            if (addr < SLOTS) m_ring[addr] = d;
            else if (addr == SLOTS) m_err = d[0];
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, '0, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) m_ring[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cq_valid", cq_valid, 0);
        chk("R1 hw_rptr", hw_rptr, 0);
        chk("R1 q_err", q_err, 0);
        chk("R1 sw_ready", sw_ready, 1);

        // R2: fresh entries (gen 1 in first lap), consumed with gaps in ready
        for (int i = 0; i < 4; i++)
            step(1, i, mk(i[0], 19'h1000 + i, 0, 1, 5'(i), i[0], 4'(i + 2), 32'h100 + i), 0, '0, 0);
        step(0, 0, '0, 0, '0, 1);
        step(0, 0, '0, 0, '0, 0);
        step(0, 0, '0, 0, '0, 1);
        // R3: software entries override ring entries
        step(0, 0, '0, 1, mk(0, 19'h7, 1, 0, 5'h1f, 1, 4'd6, 32'hAAA), 0);
        step(0, 0, '0, 1, mk(1, 19'h8, 1, 1, 5'h00, 0, 4'd3, 32'hBBB), 1);
        step(0, 0, '0, 0, '0, 1);
        idle(1);
        step(0, 0, '0, 0, '0, 1);
        step(0, 0, '0, 0, '0, 1);
        idle(2);
        // R10: fill software queue, extra push dropped, push at full with pop dropped
        for (int i = 0; i < 6; i++) step(0, 0, '0, 1, mk(0, 19'(i), 1, 0, 5'(i), 0, 4'(i), 32'hC00 + i), 0);
        step(0, 0, '0, 1, mk(0, 19'h55, 1, 0, 0, 0, 4'd9, 32'hDEAD), 1);
        for (int i = 0; i < 5; i++) step(0, 0, '0, 0, '0, 1);
        // R8 wrap: complete the first lap
        for (int i = 0; i < SLOTS; i++)
            step(1, i, mk(0, 19'h200 + i, 0, 1, 5'h1f, 1, 4'(i), 32'h300 + i), 0, '0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, '0, 0, '0, 1);
        // second lap: stale gen-1 entries are refused, gen-0 entries accepted
        for (int i = 0; i < SLOTS; i++)
            step(1, i, mk(1, 19'h400 + i, 0, 0, 5'(i), 0, 4'(i + 7), 32'h500 + i), 0, '0, 1);
        for (int i = 0; i < 10; i++) step(0, 0, '0, 0, '0, 1);
        // R9: status slot and ignored address above it
        step(1, SLOTS, 128'h1, 0, '0, 0);
        step(1, SLOTS + 1, 128'h0, 0, '0, 0);
        step(1, SLOTS + 1, mk(0, 0, 0, 1, 0, 0, 0, 0), 0, '0, 0);
        step(1, SLOTS, 128'h2, 0, '0, 0);
        idle(2);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int a;
            bit g;
            a = $urandom_range(0, SLOTS + 1);
            g = $urandom_range(0, 1);
            step($urandom_range(0, 2) == 0, a,
                 mk(g, 19'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
                    5'($urandom), $urandom_range(0, 1), 4'($urandom), $urandom),
                 $urandom_range(0, 5) == 0,
                 mk(1, 19'($urandom), 1, 0, 5'($urandom), $urandom_range(0, 1), 4'($urandom), $urandom),
                 $urandom_range(0, 2) != 0);
        end
        idle(4);
        done = 1;
        summary();
        $finish;
    end
endmodule